// File: doc/BRIEF.md
# UART Byte Queue with Packed Status Word

A synchronous byte queue meant to sit between a serial line engine and a register interface, on either the receive or the transmit path. A write strobe pushes one byte at the tail, a read strobe pops the oldest byte into a registered output, and a sticky error flag records any push into a full queue or pop from an empty one. A 16-bit status word reports the queue size, the current fill level and two interrupt-oriented bits. The meaning of those two bits depends on a direction parameter. On the receive side they report "data waiting" and "more than half full". On the transmit side they report "room for a byte" and "less than half full".

Occupancy is tracked by a three-state machine. EMPTY goes to PARTIAL on a push without a pop. PARTIAL goes to FULL on a push without a pop when one slot is left. PARTIAL goes to EMPTY on a pop without a push when one byte is left. FULL goes to PARTIAL on a pop without a push. Every other combination keeps the current state. The requested log2 depth is clamped to the range 2..10. The synchronous reset empties the queue. On a receive path, a line break is expected to be ORed into this reset.

Top module: `uart_byte_queue`

## Requirements
- R1: While `rst` is high at a clock edge, the queue becomes empty, `err` becomes 0 and `rd_data` becomes 0. All of these are visible after that edge.
- R2: Bytes leave in the order they were written. A pop sampled at a clock edge presents the oldest byte on `rd_data` after that edge. `rd_data` holds its value otherwise.
- R3: `status[15:12]` holds the effective log2 depth LW. Every bit between the fill field and bit 12 reads 0.
- R4: `status[LW+1:2]` holds the number of stored bytes modulo 2^LW, so a full queue reads 0 in this field.
- R5: With `RX_SIDE`=1, `status[0]` is 1 when at least one byte is stored. `status[1]` is 1 when more than half of the entries are occupied.
- R6: With `RX_SIDE`=0, `status[0]` is 1 when at least one entry is free. `status[1]` is 1 when fewer than half of the entries are occupied.
- R7: A pop without a push on an empty queue sets `err`, leaves the queue empty and leaves `rd_data` unchanged.
- R8: A push without a pop on a full queue is dropped and sets `err`. The stored bytes and the fill level do not change.
- R9: A push together with a pop on a full queue returns the oldest byte, appends the new byte at the tail and keeps the queue full.
- R10: A push together with a pop on an empty queue passes the written byte to `rd_data` after the edge. The queue stays empty and `err` is not set.
- R11: Once set, `err` stays 1 until reset.
- R12: A requested log2 depth below 2 is raised to 2, and one above 10 is lowered to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear (also fed by line break on receive) |
| wr_en | input | 1 | Push strobe |
| wr_data | input | DATA_W | Byte to push |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | DATA_W | Registered popped byte |
| not_empty | output | 1 | At least one byte stored |
| err | output | 1 | Sticky underflow/overflow flag |
| status | output | 16 | {log2 depth, zero pad, fill level, two interrupt bits} |

## Verification
The main path is driven with three patterns. A burst of pushes followed by pops shows ordering and the fill count. Interleaved push-and-pop in the partial state shows that the count holds while data still advances. Push-and-pop on an empty queue separates true pass-through from a stale read. Filling to the brim and then pushing, pushing with a pop, and draining separates a dropped byte from a stored one, and the full-state pass-through from an overwrite. A second instance with a too-small depth request in transmit mode shows the clamp and the transmit meaning of the interrupt bits. That instance also shows the fill field wrapping to zero when full.

// File: rtl/ubq_pkg.sv
package ubq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } ubq_state_e;

    // effective log2 depth: requested value forced into 2..10
    function automatic int clamp_log(input int req);
        if (req < 2)  return 2;
        if (req > 10) return 10;
        return req;
    endfunction

endpackage

// File: rtl/ubq_ctrl.sv
module ubq_ctrl
    import ubq_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          store,
    output logic          pop,
    output logic          bypass,
    output logic [LW-1:0] wr_ptr,
    output logic [LW-1:0] rd_ptr,
    output logic [LW:0]   count,
    output logic          err,
    output logic          not_empty
);
    localparam int          DEPTH = 1 << LW;
    localparam int          CW    = LW + 1;
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);
    localparam logic [CW-1:0] LASTV = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONEV  = CW'(1);

    ubq_state_e state_q, state_d;
    logic       is_empty, is_full, underflow, overflow;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (store && !pop) state_d = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (store && !pop && count == LASTV)     state_d = ST_FULL;
                else if (pop && !store && count == ONEV) state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (pop && !store) state_d = ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        is_empty  = (state_q == ST_EMPTY);
        is_full   = (state_q == ST_FULL);
        bypass    = wr_en && rd_en && is_empty;
        pop       = rd_en && !is_empty;
        store     = wr_en && !bypass && (!is_full || rd_en);
        underflow = rd_en && !wr_en && is_empty;
        overflow  = wr_en && !rd_en && is_full;
        not_empty = !is_empty;
    end

    // pointers, occupancy, sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            err    <= 1'b0;
        end else begin
            if (store) wr_ptr <= wr_ptr + 1'b1;
            if (pop)   rd_ptr <= rd_ptr + 1'b1;
            if (store && !pop)      count <= count + 1'b1;
            else if (pop && !store) count <= count - 1'b1;
            err <= err | underflow | overflow;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= FULLV); // R4
    AST_STATE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY) == (count == '0)); // R2
    AST_FULL_STATE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FULL) == (count == FULLV)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R11
    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
        (is_empty && rd_en && !wr_en) |=> (err && count == '0)); // R7
    AST_OVERFLOW_DROP: assert property (@(posedge clk) disable iff (rst)
        (is_full && wr_en && !rd_en) |=> (err && count == FULLV)); // R8
    AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
        (is_full && wr_en && rd_en) |=> (count == FULLV)); // R9

endmodule

// File: rtl/ubq_store.sv
module ubq_store #(
    parameter int LW     = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store,
    input  logic [LW-1:0]     wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    input  logic [LW-1:0]     rd_ptr,
    input  logic              bypass,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << LW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (store) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (bypass) rd_data <= wr_data;
        else if (pop)    rd_data <= mem[rd_ptr];
    end

endmodule

// File: rtl/ubq_status.sv
module ubq_status #(
    parameter int LW      = 4,
    parameter bit RX_SIDE = 1'b1
) (
    input  logic [LW:0]  count,
    output logic [15:0]  status
);
    localparam int            DEPTH = 1 << LW;
    localparam int            CW    = LW + 1;
    localparam logic [CW-1:0] HALF  = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic [1:0] irq;

    generate
        if (RX_SIDE) begin : g_rx
            assign irq = {count > HALF, count != '0};
        end else begin : g_tx
            assign irq = {count < HALF, count < FULLV};
        end
    endgenerate

    always_comb begin
        status            = '0;
        status[15:12]     = 4'(LW);
        status[LW+1:2]    = count[LW-1:0];
        status[1:0]       = irq;
    end

endmodule

// File: rtl/uart_byte_queue.sv
module uart_byte_queue
    import ubq_pkg::*;
#(
    parameter int LOG_DEPTH_REQ = 4,
    parameter bit RX_SIDE       = 1'b1,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              not_empty,
    output logic              err,
    output logic [15:0]       status
);
    localparam int LW = clamp_log(LOG_DEPTH_REQ);

    logic          store, pop, bypass;
    logic [LW-1:0] wr_ptr, rd_ptr;
    logic [LW:0]   count;

    ubq_ctrl #(.LW(LW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .store     (store),
        .pop       (pop),
        .bypass    (bypass),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (count),
        .err       (err),
        .not_empty (not_empty)
    );

    ubq_store #(.LW(LW), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .store   (store),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .pop     (pop),
        .rd_ptr  (rd_ptr),
        .bypass  (bypass),
        .rd_data (rd_data)
    );

    ubq_status #(.LW(LW), .RX_SIDE(RX_SIDE)) u_status (
        .count  (count),
        .status (status)
    );

    AST_EMPTY_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && wr_en && rd_en)
        |=> (rd_data == $past(wr_data) && !not_empty)); // R10
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && rd_en && !wr_en) |=> $stable(rd_data)); // R7
    AST_SIZE_FIELD: assert property (@(posedge clk) disable iff (rst)
        status[15:12] >= 4'd2 && status[15:12] <= 4'd10); // R12

endmodule

// File: tb/uart_byte_queue_tb.sv
module uart_byte_queue_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       not_empty, err;
    logic [15:0] status;

    logic       tx_wr = 1'b0, tx_rd = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic [7:0] tx_rdata;
    logic       tx_ne, tx_err;
    logic [15:0] tx_status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    uart_byte_queue #(.LOG_DEPTH_REQ(3), .RX_SIDE(1'b1), .DATA_W(8)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .not_empty(not_empty), .err(err), .status(status)
    );

    uart_byte_queue #(.LOG_DEPTH_REQ(1), .RX_SIDE(1'b0), .DATA_W(8)) u_dut_tx (
        .clk(clk), .rst(rst), .wr_en(tx_wr), .wr_data(tx_wdata), .rd_en(tx_rd),
        .rd_data(tx_rdata), .not_empty(tx_ne), .err(tx_err), .status(tx_status)
    );

    // {wr, rd, chk_rd, exp_err, exp_count[3:0], wdata[7:0], exp_rdata[7:0]}
    localparam logic [23:0] VEC [8] = '{
        24'h81A100, 24'h82A200, 24'h83A300, 24'h6200A1,
        24'hE2B1A2, 24'h6100A3, 24'h6000B1, 24'hE0C1C1
    };

    // receive instance, depth 8: {3, pad, fill[2:0], >half, nonempty}
    function automatic logic [15:0] rx_st(input int c);
        logic [15:0] s;
        s      = 16'h3000;
        s[4:2] = 3'(c % 8);
        s[1]   = (c > 4);
        s[0]   = (c != 0);
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rx_cycle(input logic w, input logic r, input logic [7:0] d);
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic tx_cycle(input logic w, input logic r, input logic [7:0] d);
        tx_wr = w; tx_rd = r; tx_wdata = d;
        @(posedge clk);
        @(negedge clk);
        tx_wr = 1'b0; tx_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state and R3 size field / zero pad
        check("R1 status after reset", status, rx_st(0));
        check("R1 not_empty after reset", not_empty, 0);
        check("R1 err after reset", err, 0);
        check("R1 rd_data after reset", rd_data, 0);
        check("R3 size field", status[15:12], 4'd3);
        check("R3 zero pad", status[11:5], 7'd0);

        // table walk: ordering, interleave, empty pass-through
        for (int i = 0; i < 8; i++) begin
            logic [23:0] v;
            v = VEC[i];
            rx_cycle(v[23], v[22], v[15:8]);
            check((i == 7) ? "R10 status" : "R4 R5 status", status, rx_st(int'(v[19:16])));
            check((i == 7) ? "R10 err" : "R2 err", err, v[20]);
            if (v[21]) check((i == 7) ? "R10 rd_data" : "R2 rd_data", rd_data, v[7:0]);
        end

        // R7 underflow: error set, data held
        rx_cycle(1'b0, 1'b1, 8'h00);
        check("R7 err on empty read", err, 1);
        check("R7 rd_data held", rd_data, 8'hC1);
        check("R7 still empty", not_empty, 0);
        // R11 sticky
        repeat (3) rx_cycle(1'b0, 1'b0, 8'h00);
        check("R11 err sticky", err, 1);
        do_reset();
        check("R11 err cleared by reset", err, 0);
        check("R1 status after second reset", status, rx_st(0));

        // fill to full, R4 R5 each step
        for (int i = 0; i < 8; i++) begin
            rx_cycle(1'b1, 1'b0, 8'h10 + 8'(i));
            check("R4 R5 fill status", status, rx_st(i + 1));
        end
        check("R4 full fill field wraps", status[4:2], 3'd0);

        // R8 overflow drop
        rx_cycle(1'b1, 1'b0, 8'hEE);
        check("R8 err on full write", err, 1);
        check("R8 count unchanged", status, rx_st(8));

        // R9 push+pop while full
        rx_cycle(1'b1, 1'b1, 8'h77);
        check("R9 oldest out", rd_data, 8'h10);
        check("R9 stays full", status, rx_st(8));

        // drain: 11..17 then 77, never EE
        for (int i = 1; i < 8; i++) begin
            rx_cycle(1'b0, 1'b1, 8'h00);
            check("R2 R8 drain order", rd_data, 8'h10 + 8'(i));
        end
        rx_cycle(1'b0, 1'b1, 8'h00);
        check("R9 new byte at tail", rd_data, 8'h77);
        check("R2 empty after drain", status, rx_st(0));

        // transmit instance, request 1 -> clamped to 2 (depth 4)
        check("R12 clamped size field", tx_status[15:12], 4'd2);
        check("R6 tx empty status", tx_status, 16'h2003);
        tx_cycle(1'b1, 1'b0, 8'h51);
        check("R6 tx one byte", tx_status, 16'h2007);
        tx_cycle(1'b1, 1'b0, 8'h52);
        check("R6 tx half", tx_status, 16'h2009);
        tx_cycle(1'b1, 1'b0, 8'h53);
        tx_cycle(1'b1, 1'b0, 8'h54);
        check("R6 R12 tx full", tx_status, 16'h2000);
        tx_cycle(1'b0, 1'b1, 8'h00);
        check("R6 tx three", tx_status, 16'h200D);
        check("R2 tx first out", tx_rdata, 8'h51);
        check("R12 tx no error", tx_err, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule